// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block routes a bank of interrupt request pins to processors. Each pin owns one 64-bit redirection entry. The entry holds the vector, the delivery mode, the trigger type, a mask and a destination. Requests on the pins are latched into a pending register. A round-robin scan then turns each pending, unmasked pin into a single message-signalled write, made of a 32-bit address and a 32-bit data word. That write is offered on a valid/ready port.

Edge-type pins fire once per rising edge. A rising edge that arrives while the pin is masked is lost. Level-type pins follow the input level. Once such a pin is delivered it is blocked by an in-service flag until an end-of-interrupt notice arrives whose vector matches the pin's vector. After that notice, a level that is still high is delivered again. Entries are loaded through a simple write port. Reset leaves every pin masked.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, no message is valid and every pin is masked, so activity on any pin produces no message until its entry is rewritten.
- R2: A rising edge on an unmasked edge-type pin (entry bit 15 = 0) produces exactly one message. Holding the input high produces no further message.
- R3: A rising edge on a masked edge-type pin (entry bit 16 = 1) is dropped. Unmasking the pin afterwards produces no message.
- R4: A level-type pin (entry bit 15 = 1) that is high and unmasked produces one message and sets its in-service flag. No further message is sent for it while that flag is set.
- R5: An end-of-interrupt carrying vector V clears the in-service flag of every pin whose entry vector (bits 7:0) equals V. A matching level pin that is still high and unmasked is delivered again. A non-matching vector has no effect.
- R6: A level pin whose input has fallen before the end-of-interrupt is not delivered again after it.
- R7: A presented message keeps valid high, and keeps its address and data unchanged, until ready is high at a clock edge.
- R8: Pins are chosen in round-robin order of ascending index with wrap-around. The search starts at the pin after the last one delivered.
- R9: Message data = vector (entry 7:0) in bits 7:0, delivery mode (entry 10:8) in bits 10:8, trigger type in bit 15, other bits 0. Message address = 0xFEE00000, with the destination (entry 63:48) in bits 19:4 and the destination mode (entry bit 11) in bit 2.
- R10: Writing an entry that selects edge type clears that pin's in-service flag, so a later level request on the pin is delivered.
- R11: A masked level pin that is high sends nothing. It is delivered once its entry is unmasked while the input is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_PINS | Interrupt request pins |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | PIN_W | Index of the entry to write |
| cfg_entry | input | 64 | New entry value |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector carried by the notice |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |

## Verification
A stuck or wrong in-service flag shows at the ports in one of two ways. A level pin either repeats its message within two cycles, or it stays silent after a matching end-of-interrupt when it should have sent a message on the very next cycle. A pending bit that is not cleared shows up as a duplicate edge message two cycles after the first one is accepted. A mishandled mask shows up as a message the scoreboard does not expect. A wrong scan pointer reorders messages from pins that are pending together, and the scoreboard, which compares messages in order, reports this.

// File: rtl/ire_pkg.sv
package ire_pkg;

    localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;

    typedef struct packed {
        logic [15:0] dest;
        logic        mask;
        logic        level;
        logic        dmode;
        logic [2:0]  dmod;
        logic [7:0]  vec;
    } rte_t;

    localparam rte_t RTE_RESET = '{dest: 16'h0, mask: 1'b1, level: 1'b0,
                                   dmode: 1'b0, dmod: 3'h0, vec: 8'h0};

    function automatic rte_t decode_entry(input logic [63:0] e);
        rte_t r;
        r.dest  = e[63:48];
        r.mask  = e[16];
        r.level = e[15];
        r.dmode = e[11];
        r.dmod  = e[10:8];
        r.vec   = e[7:0];
        return r;
    endfunction

    function automatic logic [31:0] build_addr(input rte_t r);
        return MSG_BASE | {12'h0, r.dest, 1'b0, r.dmode, 2'b00};
    endfunction

    function automatic logic [31:0] build_data(input rte_t r);
        return {16'h0, r.level, 4'h0, r.dmod, r.vec};
    endfunction

endpackage

// File: rtl/ire_entry_table.sv
module ire_entry_table
    import ire_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [PIN_W-1:0]        cfg_idx,
    input  logic [63:0]             cfg_entry,
    output rte_t [NUM_PINS-1:0]     ent_o,
    output logic [NUM_PINS-1:0]     edge_wr_o
);

    rte_t [NUM_PINS-1:0] ent_q;
    rte_t                new_ent;
    logic                cfg_unused;

    assign new_ent    = decode_entry(cfg_entry);
    assign cfg_unused = ^{cfg_entry[47:17], cfg_entry[14:12]};
    assign ent_o      = ent_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        logic hit;
        assign hit          = cfg_we && (int'(cfg_idx) == i);
        assign edge_wr_o[i] = hit && !new_ent.level;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= RTE_RESET;
            end else if (hit) begin
                ent_q[i] <= new_ent;
            end
        end
    end

endmodule

// File: rtl/ire_pend_track.sv
module ire_pend_track #(
    parameter int NUM_PINS = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        irq_i,
    input  logic [NUM_PINS-1:0]        mask_i,
    input  logic [NUM_PINS-1:0]        level_i,
    input  logic [NUM_PINS-1:0][7:0]   vec_i,
    input  logic [NUM_PINS-1:0]        load_i,
    input  logic [NUM_PINS-1:0]        edge_wr_i,
    input  logic                       eoi_valid,
    input  logic [7:0]                 eoi_vector,
    output logic [NUM_PINS-1:0]        pend_o,
    output logic [NUM_PINS-1:0]        busy_o
);

    logic [NUM_PINS-1:0] pend_q, busy_q, irq_q, eoi_hit;

    assign pend_o = pend_q;
    assign busy_o = busy_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic rise, pend_d, busy_d;
        assign rise       = irq_i[i] && !irq_q[i];
        assign eoi_hit[i] = eoi_valid && busy_q[i] && (vec_i[i] == eoi_vector);

        always_comb begin
            if (level_i[i]) begin
                pend_d = irq_i[i] ? (pend_q[i] || !busy_q[i]) : 1'b0;
            end else begin
                pend_d = (pend_q[i] && !load_i[i]) || (rise && !mask_i[i]);
            end
            busy_d = ((busy_q[i] && !eoi_hit[i]) || (load_i[i] && level_i[i]))
                     && !edge_wr_i[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
                busy_q[i] <= 1'b0;
                irq_q[i]  <= 1'b0;
            end else begin
                pend_q[i] <= pend_d;
                busy_q[i] <= busy_d;
                irq_q[i]  <= irq_i[i];
            end
        end
    end

    // R3: a masked edge pin that was idle never becomes pending
    assert_masked_edge_R3: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & $past(mask_i & ~level_i & ~pend_q)) == '0));

    // R5: a matching end-of-interrupt leaves no in-service flag behind
    assert_eoi_clear_R5: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |=> ((busy_q & $past(eoi_hit & ~(load_i & level_i))) == '0));

endmodule

// File: rtl/ire_rr_pick.sv
module ire_rr_pick #(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] elig_i,
    input  logic [PIN_W-1:0]    start_i,
    output logic                found_o,
    output logic [PIN_W-1:0]    idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int off = 0; off < NUM_PINS; off++) begin
            int cand;
            cand = int'(start_i) + off;
            if (cand >= NUM_PINS) cand = cand - NUM_PINS;
            if (!found_o && elig_i[cand]) begin
                found_o = 1'b1;
                idx_o   = PIN_W'(cand);
            end
        end
    end

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
    import ire_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_i,
    input  logic                cfg_we,
    input  logic [PIN_W-1:0]    cfg_idx,
    input  logic [63:0]         cfg_entry,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [31:0]         msg_addr,
    output logic [31:0]         msg_data
);

    rte_t [NUM_PINS-1:0]      ent;
    logic [NUM_PINS-1:0]      edge_wr, pend, busy, elig, load_vec;
    logic [NUM_PINS-1:0]      mask_v, level_v;
    logic [NUM_PINS-1:0][7:0] vec_v;
    logic [PIN_W-1:0]         ptr_q, pick_idx;
    logic                     found, load;
    rte_t                     sel;

    ire_entry_table #(.NUM_PINS(NUM_PINS)) u_table (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_entry(cfg_entry), .ent_o(ent), .edge_wr_o(edge_wr)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_fields
        assign mask_v[i]  = ent[i].mask;
        assign level_v[i] = ent[i].level;
        assign vec_v[i]   = ent[i].vec;
    end

    ire_pend_track #(.NUM_PINS(NUM_PINS)) u_track (
        .clk(clk), .rst(rst), .irq_i(irq_i), .mask_i(mask_v),
        .level_i(level_v), .vec_i(vec_v), .load_i(load_vec),
        .edge_wr_i(edge_wr), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .pend_o(pend), .busy_o(busy)
    );

    assign elig = pend & ~mask_v & (~level_v | ~busy);

    ire_rr_pick #(.NUM_PINS(NUM_PINS)) u_pick (
        .elig_i(elig), .start_i(ptr_q), .found_o(found), .idx_o(pick_idx)
    );

    assign load     = found && !msg_valid;
    assign load_vec = load ? (NUM_PINS'(1) << pick_idx) : '0;
    assign sel      = ent[pick_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            ptr_q     <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= build_addr(sel);
            msg_data  <= build_data(sel);
            ptr_q     <= (pick_idx == PIN_W'(NUM_PINS - 1)) ? '0 : pick_idx + 1'b1;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // R7: an unaccepted message holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R4: a level pin is never loaded while in service
    assert_level_block_R4: assert property (@(posedge clk) disable iff (rst)
        (load && sel.level) |-> !busy[pick_idx]);

    // R8: the chosen pin is pending and unmasked
    assert_pick_valid_R8: assert property (@(posedge clk) disable iff (rst)
        found |-> (pend[pick_idx] && !mask_v[pick_idx]));

    // R1: nothing is presented in the cycle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> !msg_valid);

endmodule

// File: tb/irq_route_engine_test.sv
module irq_route_engine_test;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_i = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [63:0] cfg_entry = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid, msg_ready;
    logic [31:0] msg_addr, msg_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur = "R1";
    logic [63:0] expq[$];

    always #2 clk = ~clk;

    irq_route_engine #(.NUM_PINS(N)) uut (
        .clk(clk), .rst(rst), .irq_i(irq_i), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_entry(cfg_entry), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    initial msg_ready = 1'b1;

    function automatic logic [63:0] ent(input logic [7:0] vec, input logic [2:0] dm,
                                        input logic lvl, input logic msk,
                                        input logic dmode, input logic [15:0] dest);
        return {dest, 31'h0, msk, lvl, 3'b0, dmode, dm, vec};
    endfunction

    task automatic expect_msg(input logic [7:0] vec, input logic [2:0] dm,
                              input logic lvl, input logic dmode, input logic [15:0] dest);
        logic [31:0] a, d;
        a = 32'hFEE0_0000 | ({16'h0, dest} << 4) | ({31'h0, dmode} << 2);
        d = {16'h0, lvl, 4'h0, dm, vec};
        expq.push_back({a, d});
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [63:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_entry = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        tick(n);
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL %s: %0d messages missing, expected 0", cur, expq.size());
            expq.delete();
        end
    endtask

    // monitor: compare accepted messages against the scoreboard in order
    always begin
        @(negedge clk);
        #1;
        if (!rst && msg_valid && msg_ready) begin
            checks++;
            if (expq.size() == 0) begin
                failures++;
                $display("FAIL %s: unexpected message addr %h data %h, expected none",
                         cur, msg_addr, msg_data);
            end else begin
                logic [63:0] e;
                e = expq.pop_front();
                if ({msg_addr, msg_data} !== e) begin
                    failures++;
                    $display("FAIL %s: addr %h data %h, expected addr %h data %h",
                             cur, msg_addr, msg_data, e[63:32], e[31:0]);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state and all pins masked
        tick(4);
        checks++;
        if (msg_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: msg_valid %b, expected 0", msg_valid);
        end
        rst = 1'b0;
        tick(1);
        irq_i = '1;
        settle(6);
        irq_i = '0;
        settle(4);

        // R2 + R9: edge delivery, single message per edge
        cur = "R2";
        wr(5, ent(8'h31, 3'd0, 1'b0, 1'b0, 1'b1, 16'h1234));
        expect_msg(8'h31, 3'd0, 1'b0, 1'b1, 16'h1234);
        irq_i[5] = 1'b1;
        settle(8);
        irq_i[5] = 1'b0;
        cur = "R9";
        wr(7, ent(8'hA5, 3'd5, 1'b0, 1'b0, 1'b0, 16'hFFFF));
        expect_msg(8'hA5, 3'd5, 1'b0, 1'b0, 16'hFFFF);
        irq_i[7] = 1'b1;
        settle(6);
        irq_i[7] = 1'b0;

        // R3: masked edge dropped
        cur = "R3";
        wr(9, ent(8'h40, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0002));
        irq_i[9] = 1'b1;
        tick(3);
        irq_i[9] = 1'b0;
        wr(9, ent(8'h40, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0002));
        settle(6);
        expect_msg(8'h40, 3'd1, 1'b0, 1'b0, 16'h0002);
        irq_i[9] = 1'b1;
        settle(6);
        irq_i[9] = 1'b0;

        // R4: level delivery blocks until end-of-interrupt
        cur = "R4";
        wr(12, ent(8'h50, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0003));
        expect_msg(8'h50, 3'd0, 1'b1, 1'b0, 16'h0003);
        irq_i[12] = 1'b1;
        settle(10);

        // R5: non-matching then matching end-of-interrupt
        cur = "R5";
        eoi(8'h51);
        settle(6);
        expect_msg(8'h50, 3'd0, 1'b1, 1'b0, 16'h0003);
        eoi(8'h50);
        settle(6);

        // R6: level dropped before end-of-interrupt
        cur = "R6";
        irq_i[12] = 1'b0;
        tick(2);
        eoi(8'h50);
        settle(6);

        // R8: round-robin from pin after 12
        cur = "R8";
        wr(3,  ent(8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0010));
        wr(10, ent(8'h6A, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0011));
        wr(20, ent(8'h74, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0012));
        expect_msg(8'h74, 3'd0, 1'b0, 1'b0, 16'h0012);
        expect_msg(8'h63, 3'd0, 1'b0, 1'b0, 16'h0010);
        expect_msg(8'h6A, 3'd0, 1'b0, 1'b0, 16'h0011);
        irq_i[3] = 1'b1; irq_i[10] = 1'b1; irq_i[20] = 1'b1;
        settle(12);
        irq_i[3] = 1'b0; irq_i[10] = 1'b0; irq_i[20] = 1'b0;

        // R7: message holds while not ready
        cur = "R7";
        wr(2, ent(8'h22, 3'd2, 1'b0, 1'b0, 1'b1, 16'h00AB));
        msg_ready = 1'b0;
        irq_i[2] = 1'b1;
        tick(6);
        checks++;
        if (msg_valid !== 1'b1 || msg_data !== 32'h0000_0222) begin
            failures++;
            $display("FAIL R7: valid %b data %h, expected valid 1 data 00000222",
                     msg_valid, msg_data);
        end
        tick(3);
        checks++;
        if (msg_valid !== 1'b1 || msg_addr !== 32'hFEE0_0AB4) begin
            failures++;
            $display("FAIL R7: valid %b addr %h, expected valid 1 addr fee00ab4",
                     msg_valid, msg_addr);
        end
        expect_msg(8'h22, 3'd2, 1'b0, 1'b1, 16'h00AB);
        msg_ready = 1'b1;
        settle(6);
        irq_i[2] = 1'b0;

        // R10: edge-type write clears in-service flag
        cur = "R10";
        expect_msg(8'h50, 3'd0, 1'b1, 1'b0, 16'h0003);
        irq_i[12] = 1'b1;
        settle(6);
        irq_i[12] = 1'b0;
        tick(2);
        wr(12, ent(8'h50, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0003));
        wr(12, ent(8'h50, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0003));
        settle(4);
        expect_msg(8'h50, 3'd0, 1'b1, 1'b0, 16'h0003);
        irq_i[12] = 1'b1;
        settle(6);
        irq_i[12] = 1'b0;

        // R11: masked level pin delivered after unmask
        cur = "R11";
        wr(15, ent(8'h77, 3'd4, 1'b1, 1'b1, 1'b0, 16'h0042));
        irq_i[15] = 1'b1;
        settle(6);
        expect_msg(8'h77, 3'd4, 1'b1, 1'b0, 16'h0042);
        wr(15, ent(8'h77, 3'd4, 1'b1, 1'b0, 1'b0, 16'h0042));
        settle(6);
        irq_i[15] = 1'b0;
        settle(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule